// File: doc/BRIEF.md
# Self-Repair Element Lifecycle Controller

Each logic element of a self-repairing cellular array carries one copy of this controller. It walks the element through a fixed life: a register self-test after reset, loading of its configuration, normal operation, and, if a fault appears inside the element, a repair phase in which the faulty element and its healthy neighbours take different paths. A faulty element ends in a terminal dead state that only a reset can clear.

The controller has three inputs besides clock and reset. The first is the level of a shared wired-OR hold line, which every element can pull high. The second is a local fault flag. The third is a flag that says the element's configuration register is full. From these it computes its own hold request for the shared line and a small set of status outputs: active, dead, repairing, and a shift enable for the configuration register. The 3-bit state code is also brought out, because neighbouring logic decodes it.

A frozen array is released only when every element has dropped its hold request. Each element therefore waits for the shared line, and never its own view, before it leaves a phase.

Top module: `elem_life_ctrl`

## Requirements
- R1: After reset the state code is 000 (test). Active, dead, repairing and shift enable are 0, and the hold request equals the inverse of the register-full flag.
- R2: The state codes on `elemState` are: test 000, die 001, fault 010, repair 100, configure 101, active 110, dead 111.
- R3: In test, a fault flag of 1 moves the element to dead (111) on the next clock edge, whatever the hold line reads.
- R4: In test with no fault, the hold request is the inverse of register-full. The element stays in test while the hold line reads 1 and moves to configure (101) on the first edge where the hold line reads 0.
- R5: In configure, the hold request and shift enable both equal the inverse of register-full, and the fault flag has no effect. The element moves to active (110) on the first edge where the hold line reads 0.
- R6: In active, the active output is 1. A fault moves the element to fault (010). With no fault, a hold line of 1 moves it to repair (100).
- R7: The fault state lasts exactly one cycle and is always followed by die (001), whatever the inputs. In it the hold request and repairing are 1 and shift enable is 0.
- R8: In die, repairing and shift enable are 1 and the hold request is the inverse of register-full. The element moves to dead when the hold line reads 0.
- R9: In repair, repairing and shift enable are 1 and the hold request is 0. The fault flag has no effect. The element returns to active when the hold line reads 0.
- R10: In dead, the dead output is 1 and the hold request, active, repairing and shift enable are 0. No input changes the state; only reset leaves it.
- R11: At most one of active, dead and repairing is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| globalHold | input | 1 | Level of the shared wired-OR hold line |
| faultSpot | input | 1 | Fault detected inside this element |
| regFull | input | 1 | Configuration register is full |
| holdReq | output | 1 | This element's pull on the shared hold line |
| active | output | 1 | Element is in normal operation |
| dead | output | 1 | Element is permanently retired |
| repairing | output | 1 | Element is taking part in a repair |
| shiftEn | output | 1 | Shift enable for the configuration register |
| elemState | output | 3 | Encoded lifecycle state |

## Verification
The block has no tunable parameters, so the bench builds the single configuration there is. That configuration covers every one of the seven state codes. The bench drives the hold line independently of the element's own request, which lets it exercise a healthy element and a faulty element through repair. It also applies faults in the states that must ignore them and hammers the dead state with every input combination. The combinational hold and shift terms are checked by toggling register-full inside a state, without taking a clock edge.

// File: rtl/elc_pkg.sv
package elc_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_TEST   = 3'b000,
    ST_DIE    = 3'b001,
    ST_FAULT  = 3'b010,
    ST_REPAIR = 3'b100,
    ST_CONFIG = 3'b101,
    ST_ACTIVE = 3'b110,
    ST_DEAD   = 3'b111
  } elcState_e;

  // one strobe per state, handed from control to output decode
  typedef struct packed {
    logic inTest;
    logic inConfig;
    logic inActive;
    logic inRepair;
    logic inFault;
    logic inDie;
    logic inDead;
  } elcStrobe_t;
endpackage

// File: rtl/elc_ctrl.sv
module elc_ctrl
  import elc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               globalHold,
  input  logic               faultSpot,
  output elcStrobe_t         strobe,
  output logic [STATE_W-1:0] stateCode
);
  elcState_e curState, nxtState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_TEST;
    else       curState <= nxtState;
  end

  always_comb begin
    nxtState = curState;
    unique case (curState)
      ST_TEST: begin
        if (faultSpot)        nxtState = ST_DEAD;
        else if (!globalHold) nxtState = ST_CONFIG;
      end
      ST_CONFIG: if (!globalHold) nxtState = ST_ACTIVE;
      ST_ACTIVE: begin
        if (faultSpot)       nxtState = ST_FAULT;
        else if (globalHold) nxtState = ST_REPAIR;
      end
      ST_FAULT:  nxtState = ST_DIE;
      ST_DIE:    if (!globalHold) nxtState = ST_DEAD;
      ST_REPAIR: if (!globalHold) nxtState = ST_ACTIVE;
      ST_DEAD:   nxtState = ST_DEAD;
      default:   nxtState = ST_TEST;
    endcase
  end

  always_comb begin
    strobe          = '0;
    strobe.inTest   = (curState == ST_TEST);
    strobe.inConfig = (curState == ST_CONFIG);
    strobe.inActive = (curState == ST_ACTIVE);
    strobe.inRepair = (curState == ST_REPAIR);
    strobe.inFault  = (curState == ST_FAULT);
    strobe.inDie    = (curState == ST_DIE);
    strobe.inDead   = (curState == ST_DEAD);
  end

  assign stateCode = curState;
endmodule

// File: rtl/elc_decode.sv
module elc_decode
  import elc_pkg::*;
(
  input  elcStrobe_t strobe,
  input  logic       regFull,
  output logic       holdReq,
  output logic       active,
  output logic       dead,
  output logic       repairing,
  output logic       shiftEn
);
  logic waitFill;

  // states that keep the array frozen until this register has filled
  assign waitFill  = strobe.inTest | strobe.inConfig | strobe.inDie;

  assign holdReq   = (waitFill & ~regFull) | strobe.inFault;
  assign active    = strobe.inActive;
  assign dead      = strobe.inDead;
  assign repairing = strobe.inRepair | strobe.inFault | strobe.inDie;
  assign shiftEn   = (strobe.inConfig & ~regFull) | strobe.inRepair | strobe.inDie;
endmodule

// File: rtl/elem_life_ctrl.sv
module elem_life_ctrl
  import elc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               globalHold,
  input  logic               faultSpot,
  input  logic               regFull,
  output logic               holdReq,
  output logic               active,
  output logic               dead,
  output logic               repairing,
  output logic               shiftEn,
  output logic [STATE_W-1:0] elemState
);
  elcStrobe_t strobe;

  elc_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .globalHold (globalHold),
    .faultSpot  (faultSpot),
    .strobe     (strobe),
    .stateCode  (elemState)
  );

  elc_decode decode_i (
    .strobe    (strobe),
    .regFull   (regFull),
    .holdReq   (holdReq),
    .active    (active),
    .dead      (dead),
    .repairing (repairing),
    .shiftEn   (shiftEn)
  );
endmodule

// File: rtl/elem_life_ctrl_chk.sv
module elem_life_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       globalHold,
  input logic       faultSpot,
  input logic       regFull,
  input logic       holdReq,
  input logic       active,
  input logic       dead,
  input logic       repairing,
  input logic       shiftEn,
  input logic [2:0] elemState
);
  // R3
  test_fault_kills_chk: assert property (@(posedge clk) disable iff (!rstN)
    (elemState == 3'b000 && faultSpot) |=> (elemState == 3'b111));

  // R6
  active_fault_to_flt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (elemState == 3'b110 && faultSpot) |=> (elemState == 3'b010));

  // R7
  flt_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (elemState == 3'b010) |=> (elemState == 3'b001));

  // R7
  flt_holds_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (elemState == 3'b010) |-> holdReq);

  // R10
  dead_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (elemState == 3'b111) |=> (elemState == 3'b111 && dead && !holdReq));

  // R9
  repair_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (elemState == 3'b100 && !globalHold) |=> (elemState == 3'b110));

  // R11
  status_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({active, dead, repairing}));
endmodule

bind elem_life_ctrl elem_life_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .globalHold(globalHold), .faultSpot(faultSpot),
  .regFull(regFull), .holdReq(holdReq), .active(active), .dead(dead),
  .repairing(repairing), .shiftEn(shiftEn), .elemState(elemState)
);

// File: tb/elem_life_ctrl_tb_top.sv
module elem_life_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic globalHold = 1'b0;
  logic faultSpot = 1'b0;
  logic regFull = 1'b0;
  logic holdReq, active, dead, repairing, shiftEn;
  logic [2:0] elemState;

  int checks = 0;
  int fails  = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  elem_life_ctrl dut_i (
    .clk(clk), .rstN(rstN), .globalHold(globalHold), .faultSpot(faultSpot),
    .regFull(regFull), .holdReq(holdReq), .active(active), .dead(dead),
    .repairing(repairing), .shiftEn(shiftEn), .elemState(elemState)
  );

  // expected vector: {state[2:0], holdReq, active, dead, repairing, shiftEn}
  task automatic expectOuts(input string req, input logic [7:0] exp);
    logic [7:0] act;
    act = {elemState, holdReq, active, dead, repairing, shiftEn};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drive(input logic gh, input logic fs, input logic rf);
    globalHold = gh; faultSpot = fs; regFull = rf;
    #0.5;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    drive(1'b1, 1'b0, 1'b0);
    step(); step();
    rstN = 1'b1;
    step();
  endtask

  // R1 R4 R5: reset, test phase and configuration
  task automatic testAndConfig();
    doReset();
    expectOuts("R1 reset state", 8'b000_1_0000);
    drive(1'b1, 1'b0, 1'b1);
    expectOuts("R4 hold drops when full", 8'b000_0_0000);
    step();
    expectOuts("R4 stays in test while hold high", 8'b000_0_0000);
    drive(1'b0, 1'b0, 1'b1);
    step();
    expectOuts("R2 R4 enter configure 101", 8'b101_0_0000);
    drive(1'b1, 1'b1, 1'b0);
    expectOuts("R5 configure not full", 8'b101_1_0001);
    step();
    expectOuts("R5 fault ignored in configure", 8'b101_1_0001);
    drive(1'b0, 1'b0, 1'b1);
    step();
    expectOuts("R2 R6 enter active 110", 8'b110_0_1000);
  endtask

  // R6 R9: healthy element through repair
  task automatic healthyRepair();
    drive(1'b1, 1'b0, 1'b1);
    step();
    expectOuts("R2 R6 active to repair 100", 8'b100_0_0011);
    drive(1'b1, 1'b1, 1'b0);
    step();
    expectOuts("R9 fault ignored in repair", 8'b100_0_0011);
    drive(1'b0, 1'b0, 1'b1);
    step();
    expectOuts("R9 repair back to active", 8'b110_0_1000);
  endtask

  // R6 R7 R8 R10: faulty element through repair into dead
  task automatic faultyPath();
    drive(1'b0, 1'b1, 1'b1);
    step();
    expectOuts("R2 R6 R7 active to fault 010", 8'b010_1_0010);
    drive(1'b0, 1'b1, 1'b1);
    step();
    expectOuts("R2 R7 fault lasts one cycle then die 001", 8'b001_0_0011);
    drive(1'b1, 1'b0, 1'b0);
    expectOuts("R8 die holds until full", 8'b001_1_0011);
    step();
    expectOuts("R8 stays in die while hold high", 8'b001_1_0011);
    drive(1'b0, 1'b0, 1'b1);
    step();
    expectOuts("R2 R8 die to dead 111", 8'b111_0_0100);
    for (int i = 0; i < 8; i++) begin
      drive(i[0], i[1], i[2]);
      step();
      expectOuts("R10 dead ignores inputs", 8'b111_0_0100);
    end
    doReset();
    expectOuts("R10 reset leaves dead", 8'b000_1_0000);
  endtask

  // R3: fault during test goes straight to dead
  task automatic testFault();
    doReset();
    drive(1'b1, 1'b1, 1'b0);
    step();
    expectOuts("R3 test fault to dead", 8'b111_0_0100);
    doReset();
    drive(1'b0, 1'b1, 1'b1);
    step();
    expectOuts("R3 fault wins over release", 8'b111_0_0100);
  endtask

  initial begin
    testAndConfig();
    healthyRepair();
    faultyPath();
    testFault();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule